// File: doc/BRIEF.md
# Programmable Power Rail Sequencer

This block switches on three switching-converter rails, two LDO rails and an enable for an external LDO in one of eight programmable orders, and switches them off again in the reverse order. An 8-bit control register, written over a simple write-strobe bus, holds a 3-bit order selector and one enable bit per rail. Each rail also has an enable pin and a power-good input. An ON-state request starts the power-up order. Dropping the request runs the same order backwards. The active-low reset stands for undervoltage lockout and reloads every register default.

A step in an order can wait for power good from the rails of the step before it. It can also wait a fixed number of clock cycles, or move on at once. A power-good wait that lasts longer than the timeout stops the order and raises a fault flag. During power-down, each step waits until the rails just turned off report not-good, or until the timeout runs out, before it turns off the next step. Rails that are not part of the selected order follow their pins while the ON request is high.

Top module: `rail_sequencer`

## Requirements
- R1: After reset the register reads {DEF_MODE, 1, 1, 1, 1, LDO2_DEF} (0x5F with the default parameters), and all rail enables, the external enable and the fault flag are low.
- R2: Register layout: bits 7:5 select the order. The rail enable bits are bit 4 converter 1, bit 3 converter 2, bit 2 converter 3, bit 1 LDO1 and bit 0 LDO2. A write is visible on the readback in the next cycle.
- R3: While a rail's enable pin is low, that rail's register bit is held at its reset default, and writes to that bit have no effect.
- R4: A rail outside the selected order is on exactly when the ON request is high, its pin is high and its register bit is 1. LDO1 is always handled this way.
- R5: A rail inside the selected order ignores its pin. It is on only once its step has been reached and while its register bit is 1.
- R6: The orders are: 000 converter 2; 001 converters 2 and 3 together; 010 converter 1, then 2 and 3 together; 011 converter 3, then 2; 110 converter 1, then 2, then 3.
- R7: Order 100: LDO2 first, with converter 3 started together with it when the mask input is 1. Converters 1 and 2 follow together. When the mask input is 0, converter 3 follows its pin.
- R8: Order 111: external-LDO enable first, LDO2 one cycle later, then converters 1 and 2 together more than DLY_CYC cycles after LDO2. Converter 3 follows its pin.
- R9: Order 101 has no steps, and every rail follows R4.
- R10: Rails of the same step turn on in the same cycle. A power-good step moves on only once every enabled rail of the current step reports good.
- R11: If a power-good wait reaches PG_TO cycles, the order stops where it is and the fault flag is set. The flag stays set until the next power-up starts.
- R12: Power-down removes steps from last to first. It waits for the removed rails to report not-good (or for PG_TO cycles) before removing the next step.
- R13: The order selector and the mask input are sampled when power-up starts. Changing them later does not affect a running order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (undervoltage lockout) |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register readback |
| en_pin_i | input | 5 | Rail enable pins {conv1, conv2, conv3, ldo1, ldo2} |
| pg_i | input | 5 | Rail power-good inputs, same order |
| on_req_i | input | 1 | ON-state request |
| dc3_mask_i | input | 1 | Order 100: converter 3 starts with LDO2 when 1 |
| rail_en_o | output | 5 | Rail enables, same order as the pins |
| ext_ldo_en_o | output | 1 | External LDO enable |
| fault_o | output | 1 | Power-good timeout fault |

## Verification
The hardest condition to reach from the ports is a power-good timeout in the middle of an order, followed by a reverse power-down that must still wait on rails that never became good. The bench feeds power good back from the rail enables through a fixed three-cycle delay. A kill mask can hold any rail's power good low, which makes the wait stall on purpose and produces the fault. Random orders, mask values and pin patterns on the rails outside each order are checked against step numbers that the bench derives from the order tables.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [1:0] {ADV_NOW, ADV_PG, ADV_DLY} adv_e;
  typedef enum logic [2:0] {ST_OFF, ST_UP, ST_DONE, ST_FAULT, ST_DOWN} state_e;

  typedef struct packed {
    logic [5:0] mask;  // [5] ext ldo, [4] dc1, [3] dc2, [2] dc3, [1] ldo1, [0] ldo2
    adv_e       adv;
  } stage_t;

  localparam logic [5:0] M_EXT  = 6'b100000;
  localparam logic [5:0] M_DC1  = 6'b010000;
  localparam logic [5:0] M_DC2  = 6'b001000;
  localparam logic [5:0] M_DC3  = 6'b000100;
  localparam logic [5:0] M_LDO2 = 6'b000001;

  function automatic logic [1:0] seq_len(input logic [2:0] mode);
    case (mode)
      3'b000, 3'b001:         return 2'd1;
      3'b010, 3'b011, 3'b100: return 2'd2;
      3'b110, 3'b111:         return 2'd3;
      default:                return 2'd0;
    endcase
  endfunction

  function automatic stage_t seq_stage(input logic [2:0] mode, input logic mbit,
                                       input logic [1:0] idx);
    stage_t s;
    s = '{mask: 6'b0, adv: ADV_PG};
    case (mode)
      3'b000: if (idx == 2'd0) s.mask = M_DC2;
      3'b001: if (idx == 2'd0) s.mask = M_DC2 | M_DC3;
      3'b010: s.mask = (idx == 2'd0) ? M_DC1 : (idx == 2'd1) ? (M_DC2 | M_DC3) : 6'b0;
      3'b011: s.mask = (idx == 2'd0) ? M_DC3 : (idx == 2'd1) ? M_DC2 : 6'b0;
      3'b100: s.mask = (idx == 2'd0) ? (M_LDO2 | (mbit ? M_DC3 : 6'b0)) :
                       (idx == 2'd1) ? (M_DC1 | M_DC2) : 6'b0;
      3'b110: s.mask = (idx == 2'd0) ? M_DC1 : (idx == 2'd1) ? M_DC2 :
                       (idx == 2'd2) ? M_DC3 : 6'b0;
      3'b111: begin
        case (idx)
          2'd0:    s = '{mask: M_EXT, adv: ADV_NOW};
          2'd1:    s = '{mask: M_LDO2, adv: ADV_DLY};
          2'd2:    s.mask = M_DC1 | M_DC2;
          default: s.mask = 6'b0;
        endcase
      end
      default: s.mask = 6'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rseq_ctrl_reg.sv
module rseq_ctrl_reg #(
  parameter logic [2:0] DEF_MODE = 3'b010,
  parameter logic       LDO2_DEF = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic [4:0] en_pin_i,
  output logic [7:0] q_o
);
  localparam logic [7:0] DEF = {DEF_MODE, 4'b1111, LDO2_DEF};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= DEF;
    end else begin
      if (wr_en_i) q_o <= wr_data_i;
      for (int i = 0; i < 5; i++)
        if (!en_pin_i[i]) q_o[i] <= DEF[i];  // pin low overrides writes
    end
  end

  for (genvar g = 0; g < 5; g++) begin : g_chk
    p_pin_default_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_pin_i[g] |=> q_o[g] == DEF[g]);
  end
endmodule

// File: rtl/rseq_engine.sv
module rseq_engine
  import rseq_pkg::*;
#(
  parameter int DLY_CYC = 50000,
  parameter int PG_TO   = 65535
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       on_req_i,
  input  logic [2:0] mode_i,
  input  logic       mbit_i,
  input  logic [4:0] rail_bits_i,
  input  logic [4:0] pg_i,
  output logic [5:0] grant_o,
  output logic [5:0] seq_set_o,
  output logic       fault_o
);
  localparam int MAXC = (DLY_CYC > PG_TO) ? DLY_CYC : PG_TO;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_C = CW'(DLY_CYC);
  localparam logic [CW-1:0] TO_C  = CW'(PG_TO);

  state_e        state_q;
  logic [1:0]    lvl_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    mode_q;
  logic          mbit_q;
  logic [4:0]    drop_q;

  logic [2:0] mode_act;
  logic       mbit_act;
  stage_t     cur;
  logic [4:0] cur_en;
  logic       adv_ok, down_ok;

  assign mode_act = (state_q == ST_OFF) ? mode_i : mode_q;
  assign mbit_act = (state_q == ST_OFF) ? mbit_i : mbit_q;
  assign cur      = seq_stage(mode_q, mbit_q, lvl_q - 2'd1);
  assign cur_en   = cur.mask[4:0] & rail_bits_i;
  assign down_ok  = ((pg_i & drop_q) == 5'b0) || (cnt_q >= TO_C);

  always_comb begin
    case (cur.adv)
      ADV_NOW: adv_ok = 1'b1;
      ADV_DLY: adv_ok = cnt_q >= DLY_C;
      default: adv_ok = (pg_i & cur_en) == cur_en;
    endcase
  end

  always_comb begin
    grant_o   = '0;
    seq_set_o = '0;
    for (int k = 0; k < 3; k++) begin
      if (2'(k) < lvl_q)             grant_o   |= seq_stage(mode_act, mbit_act, 2'(k)).mask;
      if (2'(k) < seq_len(mode_act)) seq_set_o |= seq_stage(mode_act, mbit_act, 2'(k)).mask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      lvl_q   <= 2'd0;
      cnt_q   <= '0;
      mode_q  <= 3'b0;
      mbit_q  <= 1'b1;
      drop_q  <= 5'b0;
      fault_o <= 1'b0;
    end else begin
      case (state_q)
        ST_OFF: begin
          mode_q <= mode_i;
          mbit_q <= mbit_i;
          cnt_q  <= '0;
          if (on_req_i) begin
            fault_o <= 1'b0;
            if (seq_len(mode_i) != 2'd0) begin
              state_q <= ST_UP;
              lvl_q   <= 2'd1;
            end
          end
        end
        ST_UP: begin
          if (!on_req_i) begin
            state_q <= ST_DOWN;
            drop_q  <= cur.mask[4:0];
            lvl_q   <= lvl_q - 2'd1;
            cnt_q   <= '0;
          end else if (adv_ok) begin
            cnt_q <= '0;
            if (lvl_q == seq_len(mode_q)) state_q <= ST_DONE;
            else                          lvl_q   <= lvl_q + 2'd1;
          end else if (cur.adv == ADV_PG && cnt_q >= TO_C) begin
            state_q <= ST_FAULT;
            fault_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DONE, ST_FAULT: begin
          if (!on_req_i) begin
            state_q <= ST_DOWN;
            drop_q  <= cur.mask[4:0];
            lvl_q   <= lvl_q - 2'd1;
            cnt_q   <= '0;
          end
        end
        default: begin  // ST_DOWN
          if (down_ok) begin
            cnt_q <= '0;
            if (lvl_q == 2'd0) begin
              state_q <= ST_OFF;
              drop_q  <= 5'b0;
            end else begin
              drop_q <= cur.mask[4:0];
              lvl_q  <= lvl_q - 2'd1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  p_lvl_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |->
      (lvl_q == $past(lvl_q) + 2'd1) || (lvl_q == $past(lvl_q) - 2'd1));

  p_fault_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAULT && on_req_i) |=> lvl_q == $past(lvl_q));

  p_down_mono_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DOWN) |=> lvl_q <= $past(lvl_q));
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int         DLY_CYC  = 50000,
  parameter int         PG_TO    = 65535,
  parameter logic [2:0] DEF_MODE = 3'b010,
  parameter logic       LDO2_DEF = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic [4:0] en_pin_i,
  input  logic [4:0] pg_i,
  input  logic       on_req_i,
  input  logic       dc3_mask_i,
  output logic [4:0] rail_en_o,
  output logic       ext_ldo_en_o,
  output logic       fault_o
);
  logic [7:0] reg_q;
  logic [5:0] grant, seq_set;

  rseq_ctrl_reg #(.DEF_MODE(DEF_MODE), .LDO2_DEF(LDO2_DEF)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .en_pin_i, .q_o(reg_q)
  );

  rseq_engine #(.DLY_CYC(DLY_CYC), .PG_TO(PG_TO)) u_eng (
    .clk_i, .rst_ni, .on_req_i,
    .mode_i(reg_q[7:5]), .mbit_i(dc3_mask_i), .rail_bits_i(reg_q[4:0]),
    .pg_i, .grant_o(grant), .seq_set_o(seq_set), .fault_o
  );

  assign rd_data_o    = reg_q;
  assign ext_ldo_en_o = grant[5];
  assign rail_en_o    = reg_q[4:0] & ((seq_set[4:0] & grant[4:0]) |
                                      (~seq_set[4:0] & en_pin_i & {5{on_req_i}}));

  for (genvar g = 0; g < 5; g++) begin : g_chk
    p_bit_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rail_en_o[g] |-> reg_q[g]);
  end
endmodule

// File: tb/rail_sequencer_bench.sv
module rail_sequencer_bench;
  localparam int DLY = 20;
  localparam int TO  = 40;
  localparam int PGL = 3;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [4:0] en_pin = 5'b0, pg, kill = 5'b0;
  logic       on_req = 1'b0, mbit = 1'b1;
  logic [4:0] rail_en;
  logic       ext_en, fault;
  logic [4:0] p0, p1, p2;
  int         total = 0, bad = 0, cyc = 0;
  int         rise_t[6], fall_t[6];
  logic [5:0] prev6 = 6'b0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  rail_sequencer #(.DLY_CYC(DLY), .PG_TO(TO)) u_rail_sequencer (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .en_pin_i(en_pin), .pg_i(pg), .on_req_i(on_req), .dc3_mask_i(mbit),
    .rail_en_o(rail_en), .ext_ldo_en_o(ext_en), .fault_o(fault)
  );

  // power-good model: follows enables after PGL cycles
  always_ff @(posedge clk) begin
    p0 <= rail_en; p1 <= p0; p2 <= p1; cyc <= cyc + 1;
  end
  assign pg = p2 & ~kill;

  always @(negedge clk) begin
    for (int p = 0; p < 6; p++) begin
      if ({ext_en, rail_en}[p] && !prev6[p]) rise_t[p] = cyc;
      if (!{ext_en, rail_en}[p] && prev6[p]) fall_t[p] = cyc;
    end
    prev6 = {ext_en, rail_en};
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // step index of each position [5]ext [4]dc1 [3]dc2 [2]dc3 [1]ldo1 [0]ldo2, -1 = pin controlled
  function automatic int exp_stage(input logic [2:0] m, input logic mb, input int p);
    case (m)
      3'd0: return (p == 3) ? 0 : -1;
      3'd1: return (p == 3 || p == 2) ? 0 : -1;
      3'd2: return (p == 4) ? 0 : (p == 3 || p == 2) ? 1 : -1;
      3'd3: return (p == 2) ? 0 : (p == 3) ? 1 : -1;
      3'd4: return (p == 0) ? 0 : (p == 2 && mb) ? 0 : (p == 4 || p == 3) ? 1 : -1;
      3'd6: return (p == 4) ? 0 : (p == 3) ? 1 : (p == 2) ? 2 : -1;
      3'd7: return (p == 5) ? 0 : (p == 0) ? 1 : (p == 4 || p == 3) ? 2 : -1;
      default: return -1;
    endcase
  endfunction

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_seq(input logic [2:0] m, input logic mb);
    string tag;
    int    nbad_r, nbad_f, st_a, st_b, gap;
    logic [4:0] pins;
    tag = (m == 3'd4) ? "R7" : (m == 3'd7) ? "R8" : (m == 3'd5) ? "R9" : "R6";
    for (int p = 0; p < 5; p++)
      pins[p] = (exp_stage(m, mb, p) >= 0) ? 1'b0 : 1'($urandom_range(0, 1));
    @(negedge clk);
    en_pin = pins; mbit = mb;
    wr({m, 5'b11111});
    for (int p = 0; p < 6; p++) begin rise_t[p] = -1; fall_t[p] = -1; end
    on_req = 1'b1;
    wait_cyc(100);
    nbad_r = 0;
    for (int a = 0; a < 6; a++) begin
      st_a = exp_stage(m, mb, a);
      if (st_a >= 0 && rise_t[a] < 0) nbad_r++;
      for (int b = 0; b < 6; b++) begin
        st_b = exp_stage(m, mb, b);
        if (st_a < 0 || st_b < 0) continue;
        gap = rise_t[b] - rise_t[a];
        if (st_b == st_a && gap != 0) nbad_r++;  // R10 same step, same cycle
        if (st_b == st_a + 1) begin
          if (m == 3'd7 && st_a == 0) begin if (gap != 1) nbad_r++; end
          else if (m == 3'd7 && st_a == 1) begin if (gap <= DLY) nbad_r++; end
          else if (gap <= PGL) nbad_r++;  // R10 waits for power good
        end
      end
    end
    check(nbad_r == 0, {tag, "/R10 power-up order"}, nbad_r, 0);
    check(fault == 1'b0, "R11 no fault on clean run", int'(fault), 0);
    for (int p = 0; p < 5; p++)
      if (exp_stage(m, mb, p) < 0)
        check(rail_en[p] == pins[p], (m == 3'd5) ? "R9 pin rail" : "R4 pin rail",
              int'(rail_en[p]), int'(pins[p]));
    on_req = 1'b0;
    wait_cyc(100);
    check({ext_en, rail_en} == 6'b0, "R12 all off after power-down", int'({ext_en, rail_en}), 0);
    nbad_f = 0;
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++) begin
        st_a = exp_stage(m, mb, a);
        st_b = exp_stage(m, mb, b);
        if (st_a < 0 || st_b < 0) continue;
        if (st_a == st_b && fall_t[a] != fall_t[b]) nbad_f++;
        if (st_b == st_a + 1 && (fall_t[a] - fall_t[b]) <= PGL) nbad_f++;
      end
    check(nbad_f == 0, "R12 reverse power-down order", nbad_f, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_cyc(3);
    check(rd_data == 8'h5F, "R1 reset register", rd_data, 8'h5F);
    check({fault, ext_en, rail_en} == 7'b0, "R1 reset outputs", int'({fault, ext_en, rail_en}), 0);
    rst_ni = 1'b1;
    wait_cyc(2);

    // R2 layout/readback
    en_pin = 5'b11111;
    wr(8'hA5);
    check(rd_data == 8'hA5, "R2 write readback", rd_data, 8'hA5);

    // R3 pin low holds default
    en_pin = 5'b01111;
    wr(8'h00);
    check(rd_data == 8'h10, "R3 dc1 bit forced while pin low", rd_data, 8'h10);
    en_pin = 5'b11101;
    wait_cyc(2);
    check(rd_data == 8'h12, "R3 ldo1 bit forced on pin low", rd_data, 8'h12);

    // R9/R4: mode 101, pin and bit gating
    en_pin = 5'b11111;
    wr(8'b101_10110);
    on_req = 1'b1;
    wait_cyc(2);
    check(rail_en == 5'b10110, "R9 pin mode gating", rail_en, 5'b10110);
    en_pin = 5'b01111;
    wait_cyc(1);
    check(rail_en[4] == 1'b0, "R4 pin low turns rail off", rail_en[4], 0);
    on_req = 1'b0;
    wait_cyc(1);
    check(rail_en == 5'b0, "R4 ON request low", rail_en, 0);

    // R5: sequenced rail ignores pin, follows bit
    en_pin = 5'b01000;
    wr(8'b000_10111);
    on_req = 1'b1;
    wait_cyc(20);
    check(rail_en == 5'b0, "R5 sequenced rail with bit 0 stays off", rail_en, 0);
    wr(8'b000_11111);
    check(rail_en == 5'b01000, "R5 sequenced rail on once bit set", rail_en, 5'b01000);
    on_req = 1'b0;
    wait_cyc(30);
    en_pin = 5'b0;

    // R13: mode change after start does not disturb a running order
    wr(8'b010_11111);
    on_req = 1'b1;
    wait_cyc(40);
    wr(8'b101_11111);
    wait_cyc(2);
    check(rail_en[4:2] == 3'b111, "R13 mode latched at start", rail_en[4:2], 3'b111);
    on_req = 1'b0;
    wait_cyc(60);

    // R11: power-good timeout stalls the order
    kill = 5'b01000;
    wr(8'b110_11111);
    on_req = 1'b1;
    wait_cyc(100);
    check(fault == 1'b1, "R11 fault on power-good timeout", fault, 1);
    check(rail_en[4:2] == 3'b110, "R11 order halted", rail_en[4:2], 3'b110);
    on_req = 1'b0;
    wait_cyc(100);
    check(rail_en == 5'b0, "R12 down after fault", rail_en, 0);
    check(fault == 1'b1, "R11 fault held until next start", fault, 1);
    kill = 5'b0;
    on_req = 1'b1;
    wait_cyc(3);
    check(fault == 1'b0, "R11 fault cleared on restart", fault, 0);
    on_req = 1'b0;
    wait_cyc(60);

    // directed sweep of every order, then random
    for (int m = 0; m < 8; m++) run_seq(3'(m), 1'b1);
    run_seq(3'd4, 1'b0);
    for (int i = 0; i < 12; i++) run_seq(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule